// File: doc/BRIEF.md
# Two-Format Serial Management Slave

This block is the slave end of the two-wire management bus: a management clock and one shared data line. It samples the data line on each rising clock edge. It waits for a run of at least 32 ones, which is the preamble. It then decodes the start bits, the opcode and the two address fields of each frame. Every matching frame is serviced against a small register file. Two frame formats share the bus. The direct format addresses registers 0 to 31 of a port. The extended format reaches a 16-bit register space through a stored address pointer, which the master loads with an address frame. That pointer can also advance by one after a read-with-increment.

The port address is set by a 5-bit strap. In the extended format, the device field must equal `0010` followed by a 1-bit strap. When the strap is low the device is the PHY-side extender (00100). When it is high the device is the DTE-side extender (00101). For a read, the slave leaves the line undriven for the first turnaround bit and drives 0 for the second. It then drives the 16 data bits, most significant first, each one right after a rising edge. It releases the line after the last bit.

States: `S_PRE` (hunt for the preamble), `S_ST` (second start bit), `S_OP` (opcode), `S_PAD` (port field), `S_RAD` (register or device field, and decode), `S_TA` (turnaround), `S_DATA` (16 data bits). Transitions:
- `S_PRE` stays in `S_PRE` while it counts ones, and clears the count on a 0 that comes too early.
- `S_PRE` goes to `S_ST` on a 0 once 32 ones have been seen.
- `S_ST` always goes to `S_OP`.
- `S_OP` goes to `S_PAD` after 2 bits.
- `S_PAD` goes to `S_RAD` after 5 bits.
- `S_RAD` goes to `S_TA` after 5 bits if the frame is accepted. Otherwise it goes to `S_PRE`.
- `S_TA` goes to `S_DATA` after 2 bits.
- `S_DATA` goes to `S_PRE` after 16 bits.

Top module: `mgmt_serial_slave`

## Requirements
- R1: A start is accepted only after at least 32 consecutive ones. A frame with a shorter preamble causes no write and no drive.
- R2: A direct frame has start bits 0,1 and read opcode 1,0, and its port field equals the strap. For such a frame the slave drives the addressed register's 16 bits MSB first, as described in R12. Register 1 reads the fixed ID 0x1B2C.
- R3: A direct frame with opcode 0,1 to register 0 stores the 16 data bits. A later direct read of register 0 returns them.
- R4: A frame whose port field differs from the strap causes no write and no drive.
- R5: An extended frame is serviced only when its device field equals {0010, device strap}. For any other device value, reads are not driven and address or write frames change nothing.
- R6: Extended frames use start bits 0,0. Opcode 0,0 loads the data field into the address pointer. Opcode 0,1 writes the register the pointer selects. Extended register 0 is read/write.
- R7: An extended read (opcode 1,1) returns the selected register and leaves the pointer unchanged. Extended register 1 reads the fixed ID 0x5E77.
- R8: An extended read-with-increment (opcode 1,0) returns the selected register, then adds one to the pointer.
- R9: A read of an invalid register on a valid device returns 0x0000. Invalid means direct registers other than 0 and 1, or extended pointer values other than 0 and 1.
- R10: Writes to a read-only register (direct 1, extended 1) or to an invalid register change no state.
- R11: A direct frame with opcode 0,0 or 1,1 is malformed. It causes no write and no drive, and the slave returns to hunting.
- R12: The output enable is high only during a serviced read. The turnaround's first bit is undriven and its second is driven 0. Data bit k (k = 0 for the MSB) is driven from the edge that samples turnaround bit 2 + k. The line is released at the edge that samples the last data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all sampling and updates occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_i | input | 1 | Data line as seen by the slave |
| port_addr | input | 5 | Port address strap |
| dev_sel | input | 1 | Low bit of the extended device address |
| mdio_o | output | 1 | Data value the slave drives |
| mdio_oe | output | 1 | High when the slave drives the data line |

## Verification
The bench aims at the points where a slave commonly goes wrong. A 20-bit preamble must not open a frame; a slave that starts on it would corrupt register 0. Foreign port and device values must be dropped; a slave that answers them would fight another slave on the shared line. Reserved direct opcodes must also be dropped; a slave that treats them as writes would lose stored data. For the address pointer, the bench reads twice without increment and then with increment. A wrong order of return and advance would show up as the ID appearing one frame early or late. Each driven bit is checked in its own cycle, so a one-bit skew in turnaround or data shows at once.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
    typedef enum logic [2:0] {
        S_PRE, S_ST, S_OP, S_PAD, S_RAD, S_TA, S_DATA
    } mstate_t;

    typedef enum logic [2:0] {
        ACT_DRD, ACT_DWR, ACT_XADR, ACT_XWR, ACT_XRD, ACT_XRDI
    } act_t;
endpackage

// File: rtl/mgmt_regfile.sv
module mgmt_regfile
    import mgmt_pkg::*;
#(
    parameter int          DW     = 16,
    parameter int          AW     = 5,
    parameter logic [15:0] DIR_ID = 16'h1B2C,
    parameter logic [15:0] XS_ID  = 16'h5E77
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_ext,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic          wr_ext,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          addr_ld,
    input  logic          addr_inc
);
    localparam logic [DW-1:0] ID_D = DW'(DIR_ID);
    localparam logic [DW-1:0] ID_X = DW'(XS_ID);

    logic [DW-1:0] dir_rw, ext_rw, ext_addr;

    // read mux: only two live registers per space, the rest read as zero
    always_comb begin
        rd_data = '0;
        if (rd_ext) begin
            if (ext_addr == DW'(0))      rd_data = ext_rw;
            else if (ext_addr == DW'(1)) rd_data = ID_X;
        end else begin
            if (rd_addr == AW'(0))       rd_data = dir_rw;
            else if (rd_addr == AW'(1))  rd_data = ID_D;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_rw   <= '0;
            ext_rw   <= '0;
            ext_addr <= '0;
        end else begin
            if (wr_en && !wr_ext && wr_addr == AW'(0))  dir_rw <= wr_data;
            if (wr_en && wr_ext && ext_addr == DW'(0))  ext_rw <= wr_data;
            if (addr_ld)       ext_addr <= wr_data;
            else if (addr_inc) ext_addr <= ext_addr + DW'(1);
        end
    end

    a_r8_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
        addr_inc |=> ext_addr == $past(ext_addr) + DW'(1));
    a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_ld && !addr_inc) |=> $stable(ext_addr));
    a_r10_dir_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ext && wr_addr != AW'(0)) |=> $stable(dir_rw));
    a_r10_ext_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ext && ext_addr != DW'(0)) |=> $stable(ext_rw));
endmodule

// File: rtl/mgmt_frame_fsm.sv
module mgmt_frame_fsm
    import mgmt_pkg::*;
#(
    parameter int         DW      = 16,
    parameter int         AW      = 5,
    parameter int         PRE_LEN = 32,
    parameter logic [3:0] DEV_HI  = 4'b0010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mdio_i,
    input  logic [AW-1:0] port_addr,
    input  logic          dev_sel,
    input  logic [DW-1:0] rd_data,
    output logic          rd_ext,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic          wr_ext,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          addr_ld,
    output logic          addr_inc,
    output logic          mdio_o,
    output logic          mdio_oe
);
    localparam int CW = $clog2(((PRE_LEN > DW) ? PRE_LEN : DW) + 1);
    localparam logic [CW-1:0] PRE_CNT = CW'(PRE_LEN);
    localparam logic [CW-1:0] LAST_AW = CW'(AW - 1);
    localparam logic [CW-1:0] LAST_DW = CW'(DW - 1);

    mstate_t       state;
    act_t          act, dec_act;
    logic [CW-1:0] cnt;
    logic          st_ext, go, pad_ok, dev_ok, is_rd, fin;
    logic [1:0]    op_sh;
    logic [AW-1:0] pad_sh, rad_full, dir_addr;
    logic [AW-2:0] rad_sh;
    logic [DW-1:0] dsh;

    assign rad_full = {rad_sh, mdio_i};
    assign pad_ok   = (pad_sh == port_addr);
    assign dev_ok   = (rad_full == {DEV_HI, dev_sel});

    // frame decode, evaluated while the last address bit is on the line
    always_comb begin
        go      = 1'b0;
        dec_act = ACT_DRD;
        if (st_ext) begin
            go = pad_ok && dev_ok;
            unique case (op_sh)
                2'b00: dec_act = ACT_XADR;
                2'b01: dec_act = ACT_XWR;
                2'b11: dec_act = ACT_XRD;
                2'b10: dec_act = ACT_XRDI;
            endcase
        end else begin
            unique case (op_sh)
                2'b10:   begin go = pad_ok; dec_act = ACT_DRD; end
                2'b01:   begin go = pad_ok; dec_act = ACT_DWR; end
                default: go = 1'b0;
            endcase
        end
    end

    assign rd_ext   = st_ext;
    assign rd_addr  = rad_full;
    assign is_rd    = (act == ACT_DRD) || (act == ACT_XRD) || (act == ACT_XRDI);
    assign fin      = (state == S_DATA) && (cnt == LAST_DW);
    assign wr_en    = fin && (act == ACT_DWR || act == ACT_XWR);
    assign wr_ext   = (act == ACT_XWR);
    assign wr_addr  = dir_addr;
    assign wr_data  = {dsh[DW-2:0], mdio_i};
    assign addr_ld  = fin && (act == ACT_XADR);
    assign addr_inc = fin && (act == ACT_XRDI);

    // state register and field capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_PRE;
            cnt      <= '0;
            st_ext   <= 1'b0;
            op_sh    <= '0;
            pad_sh   <= '0;
            rad_sh   <= '0;
            act      <= ACT_DRD;
            dir_addr <= '0;
        end else begin
            unique case (state)
                S_PRE: begin
                    if (mdio_i) begin
                        if (cnt != PRE_CNT) cnt <= cnt + CW'(1);
                    end else if (cnt == PRE_CNT) begin
                        state <= S_ST;
                        cnt   <= '0;
                    end else begin
                        cnt <= '0;
                    end
                end
                S_ST: begin
                    st_ext <= !mdio_i;
                    state  <= S_OP;
                end
                S_OP: begin
                    op_sh <= {op_sh[0], mdio_i};
                    if (cnt == CW'(1)) begin state <= S_PAD; cnt <= '0; end
                    else cnt <= cnt + CW'(1);
                end
                S_PAD: begin
                    pad_sh <= {pad_sh[AW-2:0], mdio_i};
                    if (cnt == LAST_AW) begin state <= S_RAD; cnt <= '0; end
                    else cnt <= cnt + CW'(1);
                end
                S_RAD: begin
                    rad_sh <= rad_full[AW-2:0];
                    if (cnt == LAST_AW) begin
                        cnt <= '0;
                        if (go) begin
                            state    <= S_TA;
                            act      <= dec_act;
                            dir_addr <= rad_full;
                        end else begin
                            state <= S_PRE;
                        end
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                S_TA: begin
                    if (cnt == CW'(1)) begin state <= S_DATA; cnt <= '0; end
                    else cnt <= cnt + CW'(1);
                end
                S_DATA: begin
                    if (cnt == LAST_DW) begin state <= S_PRE; cnt <= '0; end
                    else cnt <= cnt + CW'(1);
                end
                default: state <= S_PRE;
            endcase
        end
    end

    // line driver and data shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b0;
            dsh     <= '0;
        end else if (state == S_RAD && cnt == LAST_AW && go) begin
            dsh <= rd_data;
        end else if (state == S_TA && cnt == '0) begin
            if (is_rd) begin
                mdio_oe <= 1'b1;
                mdio_o  <= 1'b0;
            end
        end else if ((state == S_TA) || (state == S_DATA && cnt != LAST_DW)) begin
            if (is_rd) mdio_o <= dsh[DW-1];
            dsh <= {dsh[DW-2:0], mdio_i};
        end else if (fin) begin
            mdio_oe <= 1'b0;
        end
    end

    a_r12_oe_window: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> (state == S_TA || state == S_DATA));
    a_r2_first_drive_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o);
    a_r1_hunt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PRE) |-> !mdio_oe);
    a_r11_bad_op_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RAD && cnt == LAST_AW && !st_ext && op_sh[1] == op_sh[0])
        |=> state == S_PRE);
    a_r4_port_miss_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RAD && cnt == LAST_AW && !pad_ok) |=> state == S_PRE);
endmodule

// File: rtl/mgmt_serial_slave.sv
module mgmt_serial_slave
    import mgmt_pkg::*;
#(
    parameter int          DW      = 16,
    parameter int          AW      = 5,
    parameter int          PRE_LEN = 32,
    parameter logic [3:0]  DEV_HI  = 4'b0010,
    parameter logic [15:0] DIR_ID  = 16'h1B2C,
    parameter logic [15:0] XS_ID   = 16'h5E77
) (
    input  logic          mdc,
    input  logic          rst_n,
    input  logic          mdio_i,
    input  logic [AW-1:0] port_addr,
    input  logic          dev_sel,
    output logic          mdio_o,
    output logic          mdio_oe
);
    logic          rd_ext, wr_en, wr_ext, addr_ld, addr_inc;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [DW-1:0] rd_data, wr_data;

    mgmt_frame_fsm #(.DW(DW), .AW(AW), .PRE_LEN(PRE_LEN), .DEV_HI(DEV_HI)) u_fsm (
        .clk(mdc), .rst_n(rst_n), .mdio_i(mdio_i), .port_addr(port_addr),
        .dev_sel(dev_sel), .rd_data(rd_data), .rd_ext(rd_ext), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_ext(wr_ext), .wr_addr(wr_addr), .wr_data(wr_data),
        .addr_ld(addr_ld), .addr_inc(addr_inc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    mgmt_regfile #(.DW(DW), .AW(AW), .DIR_ID(DIR_ID), .XS_ID(XS_ID)) u_regs (
        .clk(mdc), .rst_n(rst_n), .rd_ext(rd_ext), .rd_addr(rd_addr),
        .rd_data(rd_data), .wr_en(wr_en), .wr_ext(wr_ext), .wr_addr(wr_addr),
        .wr_data(wr_data), .addr_ld(addr_ld), .addr_inc(addr_inc)
    );
endmodule

// File: tb/tb_mgmt_serial_slave.sv
module tb_mgmt_serial_slave;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0]  PORT = 5'h13;
    localparam logic [15:0] ID_D = 16'h1B2C;
    localparam logic [15:0] ID_X = 16'h5E77;

    logic mdc = 1'b0, rst_n = 1'b0, mdio_in = 1'b1, strap = 1'b1;
    logic mdio_o, mdio_oe;
    int n_chk = 0, n_fail = 0;

    // behavioural model state
    logic [15:0] m_dir = 16'h0, m_ext = 16'h0, m_ptr = 16'h0;

    always #(CLK_PERIOD/2) mdc = ~mdc;

    mgmt_serial_slave dut (
        .mdc(mdc), .rst_n(rst_n), .mdio_i(mdio_in), .port_addr(PORT),
        .dev_sel(strap), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    task automatic chk(input logic got, input logic exp, input string tag, input int bitno);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s bit %0d: got %b expected %b", tag, bitno, got, exp);
        end
    endtask

    function automatic logic [15:0] ext_rd(input logic [15:0] p);
        return (p == 16'd0) ? m_ext : (p == 16'd1) ? ID_X : 16'h0;
    endfunction

    task automatic frame(input int npre, input logic [1:0] st, input logic [1:0] op,
                         input logic [4:0] pad, input logic [4:0] rad,
                         input logic [15:0] wd, input string tag);
        logic b[128];
        logic eoe[128];
        logic eo[128];
        int n = 0;
        int ta;
        logic rd = 1'b0;
        logic ok;
        logic [15:0] rv = 16'h0;
        for (int i = 0; i < npre; i++) begin b[n] = 1'b1; n++; end
        for (int i = 1; i >= 0; i--) begin b[n] = st[i]; n++; end
        for (int i = 1; i >= 0; i--) begin b[n] = op[i]; n++; end
        for (int i = 4; i >= 0; i--) begin b[n] = pad[i]; n++; end
        for (int i = 4; i >= 0; i--) begin b[n] = rad[i]; n++; end
        ta = n;
        ok = (npre >= 32) && (pad == PORT);
        if (ok && st == 2'b01) begin
            if (op == 2'b10) begin
                rd = 1'b1;
                rv = (rad == 5'd0) ? m_dir : (rad == 5'd1) ? ID_D : 16'h0;
            end else if (op == 2'b01 && rad == 5'd0) begin
                m_dir = wd;
            end
        end else if (ok && st == 2'b00 && rad == {4'b0010, strap}) begin
            unique case (op)
                2'b00: m_ptr = wd;
                2'b01: if (m_ptr == 16'd0) m_ext = wd;
                2'b11: begin rd = 1'b1; rv = ext_rd(m_ptr); end
                2'b10: begin rd = 1'b1; rv = ext_rd(m_ptr); m_ptr = m_ptr + 16'd1; end
            endcase
        end
        b[n] = 1'b1; b[n+1] = rd ? 1'b1 : 1'b0;
        for (int j = 0; j < 16; j++) b[n+2+j] = rd ? 1'b1 : wd[15-j];
        n += 18;
        for (int i = 0; i < n; i++) begin eoe[i] = 1'b0; eo[i] = 1'b0; end
        if (rd) begin
            eoe[ta] = 1'b1;   eo[ta] = 1'b0;
            eoe[ta+1] = 1'b1; eo[ta+1] = rv[15];
            for (int j = 0; j < 15; j++) begin eoe[ta+2+j] = 1'b1; eo[ta+2+j] = rv[14-j]; end
        end
        for (int i = 0; i <= n; i++) begin
            @(negedge mdc);
            if (i > 0) begin
                chk(mdio_oe, eoe[i-1], tag, i-1);
                if (eoe[i-1]) chk(mdio_o, eo[i-1], tag, i-1);
            end
            if (i < n) mdio_in = b[i];
        end
        mdio_in = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge mdc);
        rst_n = 1'b1;
        @(negedge mdc);
        chk(mdio_oe, 1'b0, "R12 reset idle", 0);
        frame(32, 2'b01, 2'b10, PORT, 5'd1, 16'h0, "R2 direct read ID");
        frame(32, 2'b01, 2'b01, PORT, 5'd0, 16'hA5C3, "R3 direct write");
        frame(32, 2'b01, 2'b10, PORT, 5'd0, 16'h0, "R3 direct readback");
        frame(32, 2'b01, 2'b01, PORT, 5'd1, 16'h0000, "R10 direct write read-only");
        frame(32, 2'b01, 2'b10, PORT, 5'd1, 16'h0, "R10 read-only kept");
        frame(32, 2'b01, 2'b01, PORT, 5'd9, 16'hFFFF, "R10 direct write invalid");
        frame(32, 2'b01, 2'b10, PORT, 5'd9, 16'h0, "R9 direct invalid reads zero");
        frame(32, 2'b01, 2'b01, PORT ^ 5'h1, 5'd0, 16'h1111, "R4 foreign port write");
        frame(32, 2'b01, 2'b10, PORT ^ 5'h1, 5'd0, 16'h0, "R4 foreign port read");
        frame(32, 2'b01, 2'b10, PORT, 5'd0, 16'h0, "R4 register kept");
        frame(20, 2'b01, 2'b01, PORT, 5'd0, 16'hDEAD, "R1 short preamble write");
        frame(40, 2'b01, 2'b10, PORT, 5'd0, 16'h0, "R1 long preamble read");
        frame(32, 2'b01, 2'b00, PORT, 5'd0, 16'h0000, "R11 opcode 00");
        frame(32, 2'b01, 2'b11, PORT, 5'd0, 16'h0, "R11 opcode 11");
        frame(32, 2'b01, 2'b10, PORT, 5'd0, 16'h0, "R11 register kept");
        frame(32, 2'b00, 2'b00, PORT, 5'b00101, 16'h0000, "R6 pointer load");
        frame(32, 2'b00, 2'b01, PORT, 5'b00101, 16'h3C3C, "R6 extended write");
        frame(32, 2'b00, 2'b11, PORT, 5'b00101, 16'h0, "R7 extended read");
        frame(32, 2'b00, 2'b11, PORT, 5'b00101, 16'h0, "R7 pointer unchanged");
        frame(32, 2'b00, 2'b10, PORT, 5'b00101, 16'h0, "R8 read-increment");
        frame(32, 2'b00, 2'b11, PORT, 5'b00101, 16'h0, "R8 pointer advanced");
        frame(32, 2'b00, 2'b01, PORT, 5'b00101, 16'h0000, "R10 extended write read-only");
        frame(32, 2'b00, 2'b10, PORT, 5'b00101, 16'h0, "R8 R10 read-increment ID");
        frame(32, 2'b00, 2'b11, PORT, 5'b00101, 16'h0, "R9 extended invalid reads zero");
        frame(32, 2'b00, 2'b00, PORT, 5'b00101, 16'h0007, "R6 pointer load 7");
        frame(32, 2'b00, 2'b11, PORT, 5'b00101, 16'h0, "R9 pointer 7 reads zero");
        frame(32, 2'b00, 2'b00, PORT, 5'b00101, 16'h0000, "R6 pointer load 0");
        frame(32, 2'b00, 2'b11, PORT, 5'b00100, 16'h0, "R5 wrong device read");
        frame(32, 2'b00, 2'b00, PORT, 5'b00100, 16'h0001, "R5 wrong device pointer");
        frame(32, 2'b00, 2'b01, PORT, 5'b00100, 16'h0F0F, "R5 wrong device write");
        frame(32, 2'b00, 2'b11, PORT, 5'b00101, 16'h0, "R5 state kept");
        @(negedge mdc);
        strap = 1'b0;
        frame(32, 2'b00, 2'b11, PORT, 5'b00100, 16'h0, "R5 strap low device");
        frame(32, 2'b00, 2'b11, PORT, 5'b00101, 16'h0, "R5 strap low rejects 00101");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule